// File: doc/BRIEF.md
# Configurable Framing Serial Transmitter

This block serialises one character at a time onto an asynchronous serial line. Software (or a neighbouring bus adapter) writes an 8-bit format register, a 16-bit divider register and a byte-wide data register through three write strobes. The format register gates the clock, enables transmission and selects the bit order, the parity mode, the character length and the number of stop bits. An internal rate generator makes one bit time last twice the divider value in base clock cycles, with small divider values clamped to 4.

A write to the data register is accepted only when the block is idle with both enable bits set. The frame format and the data bits are captured when the write is accepted, so later format writes do not disturb a frame in flight. While a frame is in flight the block reports busy, and a one-cycle completion pulse marks the end of the last stop bit. Clearing the clock enable aborts the frame and returns the line to its idle high level.

The sequencer has six states: IDLE (line high, waiting), START (start bit, line low), DATA (data bits, one per bit time), PARITY (optional parity bit), STOP1 (first stop bit) and STOP2 (optional second stop bit). Transitions: IDLE to START on an accepted write; START to DATA after one bit time; DATA to PARITY or to STOP1 after the last data bit, depending on whether parity is on; PARITY to STOP1 after one bit time; STOP1 to STOP2 or to IDLE, depending on the stop count; STOP2 to IDLE after one bit time. From any state the sequencer goes to IDLE on the first edge at which the clock enable reads clear.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is 1, busy is 0 and the completion pulse is 0.
- R2: A data write accepted at a clock edge makes busy 1 and drives the start bit (line 0) from that edge on.
- R3: Every bit of a frame lasts exactly 2*D clock cycles, where D is the divider register value, or 4 when that value is below 4.
- R4: Format bit 4 selects the bit order: 1 sends data bit 0 first, 0 sends the most significant data bit of the character first.
- R5: Format bit 1 selects the length: 1 sends 8 data bits, 0 sends 7 data bits (data bits 6..0) and bit 7 of the written byte has no effect on the line.
- R6: Format bits 3:2 select parity after the data bits: 00 none, 01 a bit always sent as 0, 10 odd parity (data bits plus parity hold an odd number of ones), 11 even parity.
- R7: Format bit 0 selects the stop count: 1 sends two stop bits, 0 sends one; stop bits are 1.
- R8: Busy stays 1 until the last stop bit has lasted its full bit time; at that edge busy falls and the completion output is 1 for exactly one cycle.
- R9: A data write while busy is ignored: the frame in flight is unchanged and no further frame follows.
- R10: A data write is ignored when format bit 7 (clock enable) or bit 6 (transmit enable) is 0: the line stays 1 and busy stays 0.
- R11: When format bit 7 is written to 0 during a frame, the line is 1 and busy is 0 one cycle after the write lands, and no completion pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_wr | input | 1 | Format register write strobe |
| fmt_wdata | input | 8 | Format register write value |
| div_wr | input | 1 | Divider register write strobe |
| div_wdata | input | 16 | Divider register write value |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Character to send |
| txd | output | 1 | Serial line, idles high |
| tx_busy | output | 1 | High while a character is being sent |
| tx_done | output | 1 | One-cycle pulse at the end of the last stop bit |

## Verification
The hardest situations to reach are a data write landing in the middle of a frame and the clock enable dropping partway through one, since the port sequence must be timed against the bit clock. The bench drives the competing write one half bit into the start bit and the enable clear three bit times into a frame, counting edges from the accepting edge. Around that, it sweeps all 32 combinations of order, parity, length and stop count with two data bytes, comparing the line on every cycle against a frame it builds arithmetically, and repeats with clamped and unclamped divider values.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_EVEN = 2'b11
    } par_mode_e;

endpackage

// File: rtl/uft_baud_gen.sv
module uft_baud_gen #(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] eff_div;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        eff_div = (div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div;
        limit   = {eff_div, 1'b0};
    end

    assign tick = en && !restart && (cnt_q >= limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/uft_frame_pack.sv
module uft_frame_pack
    import uft_pkg::*;
(
    input  logic [CHAR_W-1:0] char_in,
    input  logic              lsb_first,
    input  logic              len8,
    input  par_mode_e         par_mode,
    output logic [CHAR_W-1:0] ord_bits,
    output logic              par_bit
);
    logic [CHAR_W-1:0] masked;

    assign masked = len8 ? char_in : {1'b0, char_in[CHAR_W-2:0]};

    for (genvar i = 0; i < CHAR_W; i++) begin : g_order
        if (i < CHAR_W - 1) begin : g_short
            assign ord_bits[i] = lsb_first ? masked[i]
                               : (len8 ? masked[CHAR_W-1-i] : masked[CHAR_W-2-i]);
        end else begin : g_top
            assign ord_bits[i] = lsb_first ? masked[i]
                               : (len8 ? masked[0] : 1'b0);
        end
    end

    always_comb begin
        unique case (par_mode)
            PAR_NONE: par_bit = 1'b0;
            PAR_ZERO: par_bit = 1'b0;
            PAR_ODD:  par_bit = ~^masked;
            PAR_EVEN: par_bit = ^masked;
            default:  par_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/uft_tx_fsm.sv
module uft_tx_fsm
    import uft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_req,
    input  logic              tick,
    input  logic [CHAR_W-1:0] ord_bits,
    input  logic              par_bit,
    input  logic              par_on,
    input  logic              len8,
    input  logic              stop2,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(CHAR_W);

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              par_q, par_on_q, len8_q, stop2_q, done_q;
    logic              last_data, finish;

    assign last_data = (idx_q == (len8_q ? IDX_W'(CHAR_W - 1) : IDX_W'(CHAR_W - 2)));
    assign finish    = tick && (((state_q == ST_STOP1) && !stop2_q) || (state_q == ST_STOP2));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_START;
            ST_START:  if (tick) state_d = ST_DATA;
            ST_DATA:   if (tick && last_data) state_d = par_on_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (tick) state_d = ST_STOP1;
            ST_STOP1:  if (tick) state_d = stop2_q ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            shreg_q  <= '0;
            par_q    <= 1'b0;
            par_on_q <= 1'b0;
            len8_q   <= 1'b0;
            stop2_q  <= 1'b0;
            done_q   <= 1'b0;
        end else if (!en) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if ((state_q == ST_IDLE) && start_req) begin
                idx_q    <= '0;
                shreg_q  <= ord_bits;
                par_q    <= par_bit;
                par_on_q <= par_on;
                len8_q   <= len8;
                stop2_q  <= stop2;
            end else if ((state_q == ST_DATA) && tick) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[idx_q];
            ST_PARITY: txd = par_q;
            ST_STOP1:  txd = 1'b1;
            ST_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
        busy = (state_q != ST_IDLE);
        done = done_q;
    end

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8
    done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && txd && !done));

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(len8_q) && $stable(stop2_q) && $stable(par_on_q)));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int MIN_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_wr,
    input  logic [7:0]        fmt_wdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] data_wdata,
    output logic              txd,
    output logic              tx_busy,
    output logic              tx_done
);
    logic              clk_on_q, tx_on_q, lsb_first_q, len8_q, stop2_q;
    par_mode_e         par_q;
    logic [DIV_W-1:0]  div_q;
    logic              fmt_unused;
    logic              start_req, tick, par_bit;
    logic [CHAR_W-1:0] ord_bits;

    assign fmt_unused = fmt_wdata[5];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_on_q    <= 1'b0;
            tx_on_q     <= 1'b0;
            lsb_first_q <= 1'b0;
            par_q       <= PAR_NONE;
            len8_q      <= 1'b0;
            stop2_q     <= 1'b0;
            div_q       <= DIV_W'(MIN_DIV);
        end else begin
            if (fmt_wr) begin
                clk_on_q    <= fmt_wdata[7];
                tx_on_q     <= fmt_wdata[6];
                lsb_first_q <= fmt_wdata[4];
                par_q       <= par_mode_e'(fmt_wdata[3:2]);
                len8_q      <= fmt_wdata[1];
                stop2_q     <= fmt_wdata[0];
            end
            if (div_wr) begin
                div_q <= div_wdata;
            end
        end
    end

    assign start_req = data_wr && clk_on_q && tx_on_q && !tx_busy;

    uft_baud_gen #(
        .DIV_W  (DIV_W),
        .MIN_DIV(MIN_DIV)
    ) baud_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (clk_on_q),
        .restart(start_req),
        .div    (div_q),
        .tick   (tick)
    );

    uft_frame_pack pack_i (
        .char_in  (data_wdata),
        .lsb_first(lsb_first_q),
        .len8     (len8_q),
        .par_mode (par_q),
        .ord_bits (ord_bits),
        .par_bit  (par_bit)
    );

    uft_tx_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_on_q),
        .start_req(start_req),
        .tick     (tick),
        .ord_bits (ord_bits),
        .par_bit  (par_bit),
        .par_on   (par_q != PAR_NONE),
        .len8     (len8_q),
        .stop2    (stop2_q),
        .txd      (txd),
        .busy     (tx_busy),
        .done     (tx_done)
    );

    // R10
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !(clk_on_q && tx_on_q)) |=> !tx_busy);

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_wr = 1'b0;
    logic [7:0] fmt_wdata = '0;
    logic       div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       txd, tx_busy, tx_done;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    uart_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n),
        .fmt_wr(fmt_wr), .fmt_wdata(fmt_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int build(input logic [7:0] c, input logic [7:0] d, output logic [11:0] f);
        int n = 0;
        int len = c[1] ? 8 : 7;
        int ones = 0;
        f = '1;
        f[n] = 1'b0; n++;
        for (int i = 0; i < len; i++) begin
            f[n] = c[4] ? d[i] : d[len-1-i];
            ones += int'(d[i]);
            n++;
        end
        case (c[3:2])
            2'b01: begin f[n] = 1'b0; n++; end
            2'b10: begin f[n] = (ones % 2 == 0); n++; end
            2'b11: begin f[n] = (ones % 2 == 1); n++; end
            default: ;
        endcase
        f[n] = 1'b1; n++;
        if (c[0]) begin f[n] = 1'b1; n++; end
        return n;
    endfunction

    task automatic set_fmt(input logic [7:0] v);
        @(negedge clk); fmt_wr = 1'b1; fmt_wdata = v;
        @(negedge clk); fmt_wr = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] v);
        @(negedge clk); div_wr = 1'b1; div_wdata = v;
        @(negedge clk); div_wr = 1'b0;
    endtask

    // one frame, checked on every cycle; poke drives a competing write mid start bit
    task automatic run_frame(input logic [7:0] c, input logic [7:0] d, input int dd, input bit poke);
        logic [11:0] f;
        int n = build(c, d, f);
        int bt = 2 * dd;
        @(negedge clk); data_wr = 1'b1; data_wdata = d;
        @(posedge clk); #1; data_wr = 1'b0;
        chk(txd == 1'b0 && tx_busy == 1'b1, "R2 start bit", {txd, tx_busy}, 1);
        for (int t = 1; t <= n * bt + 1; t++) begin
            @(posedge clk); #1;
            if (poke && t == dd) begin data_wr = 1'b1; data_wdata = ~d; end
            if (poke && t == dd + 1) data_wr = 1'b0;
            if (t < n * bt) begin
                chk(txd == f[t / bt], "R3 R4 R5 R6 R7 R9 line bit", int'(txd), int'(f[t / bt]));
                chk(tx_busy == 1'b1 && tx_done == 1'b0, "R8 busy in frame", {tx_busy, tx_done}, 2);
            end else if (t == n * bt) begin
                chk(tx_busy == 1'b0 && tx_done == 1'b1 && txd == 1'b1, "R8 frame end",
                    {txd, tx_busy, tx_done}, 5);
            end else begin
                chk(tx_done == 1'b0 && tx_busy == 1'b0, "R8 R9 after end", {tx_busy, tx_done}, 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(txd == 1'b1 && tx_busy == 1'b0 && tx_done == 1'b0, "R1 reset state",
            {txd, tx_busy, tx_done}, 4);

        // full format sweep at the minimum divider
        set_div(16'd4);
        for (int fm = 0; fm < 32; fm++) begin
            logic [7:0] c = 8'hC0 | {3'b000, fm[4], fm[3:2], fm[1], fm[0]};
            set_fmt(c);
            run_frame(c, 8'hB5, 4, 1'b0);
            run_frame(c, 8'h4E, 4, 1'b0);
        end

        // R3 clamp: divider 1 behaves as 4; divider 6 and 5 unclamped
        set_div(16'd1);
        set_fmt(8'hD2);
        run_frame(8'hD2, 8'h93, 4, 1'b0);
        set_div(16'd6);
        set_fmt(8'hCF);
        run_frame(8'hCF, 8'h3C, 6, 1'b0);
        set_div(16'd5);
        set_fmt(8'hD9);
        run_frame(8'hD9, 8'hFF, 5, 1'b0);

        // R9 write during a frame
        set_div(16'd4);
        set_fmt(8'hCA);
        run_frame(8'hCA, 8'h61, 4, 1'b1);
        set_fmt(8'hD3);
        run_frame(8'hD3, 8'h80, 4, 1'b1);

        // R10 writes with an enable bit clear
        for (int k = 0; k < 2; k++) begin
            logic [7:0] c = (k == 0) ? 8'h92 : 8'h52;
            set_fmt(c);
            @(negedge clk); data_wr = 1'b1; data_wdata = 8'h00;
            @(negedge clk); data_wr = 1'b0;
            for (int t = 0; t < 20; t++) begin
                @(negedge clk);
                chk(txd == 1'b1 && tx_busy == 1'b0, "R10 disabled write ignored", {txd, tx_busy}, 2);
            end
        end

        // R11 clock enable cleared mid-frame
        set_fmt(8'hD2);
        @(negedge clk); data_wr = 1'b1; data_wdata = 8'h00;
        @(negedge clk); data_wr = 1'b0;
        repeat (24) @(negedge clk);
        chk(txd == 1'b0 && tx_busy == 1'b1, "R11 frame running", {txd, tx_busy}, 1);
        fmt_wr = 1'b1; fmt_wdata = 8'h12;
        @(posedge clk); #1; fmt_wr = 1'b0;
        @(posedge clk); #1;
        chk(txd == 1'b1 && tx_busy == 1'b0 && tx_done == 1'b0, "R11 abort idle",
            {txd, tx_busy, tx_done}, 4);
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            chk(txd == 1'b1 && tx_busy == 1'b0 && tx_done == 1'b0, "R11 stays idle",
                {txd, tx_busy, tx_done}, 4);
        end

        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule